// File: doc/BRIEF.md
# Flag-Steered Stereo Serial Receiver

This block takes in a synchronous serial stream whose bit clock and word sync both come from outside the chip. It has no divider of its own. All four serial inputs (bit clock, word sync, data and steering flag) pass through a synchronizer into the system clock domain. The block then works on each falling edge of the bit clock. A sync pulse one bit long marks the first bit of a word. Sixteen bits follow, MSB first. The steering flag is taken at the last bit of the word. A clear flag sends the finished word to the left ring buffer, and a set flag sends it to the right ring buffer. Each ring holds two words.

The receiver is a three-state machine:
- **OFF** is held while `rx_en` is low.
- **OFF → HUNT** happens when `rx_en` goes high.
- **HUNT → SHIFT** happens on a falling bit-clock edge that carries the sync pulse.
- **SHIFT → SHIFT** (restart) happens when a sync pulse arrives before the word is complete.
- **SHIFT → HUNT** happens when the sixteenth bit arrives. The word is stored at that point.
- **HUNT/SHIFT → OFF** happens whenever `rx_en` drops.

Software reads each ring through a combinational read port. It sees the ring's write pointer, so it knows which slot was filled last. A read strobe frees the addressed slot. A sticky overrun flag records any write into a slot that still holds an unread word.

Top module: `stereo_flag_rx`

## Requirements
- R1: After reset, both write pointers are 0, `word_done` is 0, `overrun` is 0 and both read ports return 0 for every address.
- R2: Words are 16 bits long. The first bit received is the MSB. Each bit is taken on a falling edge of `sclk`.
- R3: A word starts with the bit during which `fsync` is high at a falling `sclk` edge. After a complete word the receiver waits for the next `fsync`. A new word may begin on the very next bit.
- R4: The `side_flag` level at the falling edge of a word's last bit selects the buffer: 0 = left, 1 = right. Its level on the other bits of the word has no effect.
- R5: Each buffer has 2 slots. A write fills the slot at its write pointer, and the pointer then advances by one, wrapping from 1 to 0. The other buffer's pointer does not change.
- R6: While `rx_en` is low, no word is stored. A word in progress when `rx_en` falls is dropped. After `rx_en` rises, reception waits for an `fsync`, so the tail of a word already under way is ignored.
- R7: An `fsync` that arrives before a word is complete restarts the word, with that bit as the new MSB. The partial word is discarded.
- R8: `word_done` pulses for one clock cycle per stored word. The pulse comes in the first cycle in which the new word and the advanced pointer are visible.
- R9: Writing a slot whose previous word has not been freed by a read strobe (`*_rd_en` with `*_rd_addr` pointing at it) sets `overrun`. `overrun` stays set until reset.
- R10: `*_rd_data` shows the slot selected by `*_rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable |
| sclk | input | 1 | External serial bit clock |
| fsync | input | 1 | External bit-long word sync |
| sdata | input | 1 | Serial data |
| side_flag | input | 1 | Buffer steering flag (0 left, 1 right) |
| l_rd_addr | input | PTR_W | Left buffer read address |
| l_rd_en | input | 1 | Left read strobe, frees addressed slot |
| l_rd_data | output | WORD_W | Left buffer read data |
| l_wr_ptr | output | PTR_W | Left buffer write pointer |
| r_rd_addr | input | PTR_W | Right buffer read address |
| r_rd_en | input | 1 | Right read strobe, frees addressed slot |
| r_rd_data | output | WORD_W | Right buffer read data |
| r_wr_ptr | output | PTR_W | Right buffer write pointer |
| word_done | output | 1 | One-cycle pulse per stored word |
| overrun | output | 1 | Sticky unread-slot overwrite flag |

## Verification
Suppose the bit counter or the state machine holds a wrong value. Then within one word time the stored value appears shifted or truncated, or `word_done` arrives early or not at all. The pointers also stop matching the count of words sent. A steering error shows up at the very next word: the wrong pointer moves. Occupancy errors appear only as an `overrun` that is wrong in either direction on the third unread write to a buffer. For that reason, one test stops reading and counts the writes.

// File: rtl/sfrx_pkg.sv
package sfrx_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_HUNT  = 2'd1,
        ST_SHIFT = 2'd2
    } rx_state_t;

    localparam int SIDE_LEFT  = 0;
    localparam int SIDE_RIGHT = 1;
    localparam int NUM_SIDES  = 2;
endpackage

// File: rtl/sfrx_sync.sv
module sfrx_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sfrx_deser.sv
module sfrx_deser
    import sfrx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              sclk_s,
    input  logic              fs_s,
    input  logic              sd_s,
    input  logic              flag_s,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_q,
    output logic              word_side
);
    localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    rx_state_t         state, next_state;
    logic              sclk_d;
    logic              fall;
    logic [CW-1:0]     cnt;
    logic [WORD_W-1:0] shreg;

    assign fall = sclk_d & ~sclk_s;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= next_state;
    end

    // transitions
    always_comb begin
        next_state = state;
        unique case (state)
            ST_OFF:   if (rx_en) next_state = ST_HUNT;
            ST_HUNT: begin
                if (!rx_en)              next_state = ST_OFF;
                else if (fall && fs_s)   next_state = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!rx_en)                   next_state = ST_OFF;
                else if (fall && fs_s)        next_state = ST_SHIFT;
                else if (fall && cnt == LAST) next_state = ST_HUNT;
            end
            default: next_state = ST_OFF;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d    <= 1'b0;
            cnt       <= '0;
            shreg     <= '0;
            word_q    <= '0;
            word_side <= 1'b0;
            word_vld  <= 1'b0;
        end else begin
            sclk_d   <= sclk_s;
            word_vld <= 1'b0;
            unique case (state)
                ST_OFF: cnt <= '0;
                ST_HUNT: begin
                    if (rx_en && fall && fs_s) begin
                        shreg <= {{(WORD_W-1){1'b0}}, sd_s};
                        cnt   <= CW'(1);
                    end
                end
                ST_SHIFT: begin
                    if (rx_en && fall) begin
                        if (fs_s) begin
                            shreg <= {{(WORD_W-1){1'b0}}, sd_s};
                            cnt   <= CW'(1);
                        end else begin
                            shreg <= {shreg[WORD_W-2:0], sd_s};
                            if (cnt == LAST) begin
                                word_q    <= {shreg[WORD_W-2:0], sd_s};
                                word_side <= flag_s;
                                word_vld  <= 1'b1;
                                cnt       <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // R6: a finished word only while enabled
    a_r6_store_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(rx_en));
    // R3: a finished word only leaves the shifting state
    a_r3_done_from_shift: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(state) == ST_SHIFT);
    // R3: after a word the receiver is back hunting or off
    a_r3_return_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> state != ST_SHIFT || $past(!rx_en) == 1'b0);
endmodule

// File: rtl/sfrx_ring.sv
module sfrx_ring #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 2,
    parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic              ovr_evt
);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  occ;

    assign rd_data = mem[rd_addr];
    assign ovr_evt = we && occ[wr_ptr] && !(rd_en && rd_addr == wr_ptr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            occ    <= '0;
            wr_ptr <= '0;
        end else begin
            if (we) begin
                mem[wr_ptr] <= wdata;
                wr_ptr      <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (we && wr_ptr == PTR_W'(i))           occ[i] <= 1'b1;
                else if (rd_en && rd_addr == PTR_W'(i))  occ[i] <= 1'b0;
            end
        end
    end

    // R5: pointer holds when nothing is written
    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(wr_ptr));
    // R5: pointer moves on every write
    a_r5_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (we && DEPTH > 1) |=> !$stable(wr_ptr));
    // R10: a written word is readable at its slot next cycle
    a_r10_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(wr_ptr)] == $past(wdata));
endmodule

// File: rtl/stereo_flag_rx.sv
module stereo_flag_rx
    import sfrx_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int DEPTH       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int PTR_W       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              sclk,
    input  logic              fsync,
    input  logic              sdata,
    input  logic              side_flag,
    input  logic [PTR_W-1:0]  l_rd_addr,
    input  logic              l_rd_en,
    output logic [WORD_W-1:0] l_rd_data,
    output logic [PTR_W-1:0]  l_wr_ptr,
    input  logic [PTR_W-1:0]  r_rd_addr,
    input  logic              r_rd_en,
    output logic [WORD_W-1:0] r_rd_data,
    output logic [PTR_W-1:0]  r_wr_ptr,
    output logic              word_done,
    output logic              overrun
);
    logic [3:0]        ser_s;
    logic              word_vld, word_side;
    logic [WORD_W-1:0] word_q;

    logic [NUM_SIDES-1:0] we_v, rd_en_v, ovr_v;
    logic [PTR_W-1:0]     rd_addr_v [NUM_SIDES];
    logic [PTR_W-1:0]     ptr_v     [NUM_SIDES];
    logic [WORD_W-1:0]    rd_data_v [NUM_SIDES];

    sfrx_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({side_flag, sdata, fsync, sclk}),
        .dout (ser_s)
    );

    sfrx_deser #(.WORD_W(WORD_W)) deser_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .sclk_s   (ser_s[0]),
        .fs_s     (ser_s[1]),
        .sd_s     (ser_s[2]),
        .flag_s   (ser_s[3]),
        .word_vld (word_vld),
        .word_q   (word_q),
        .word_side(word_side)
    );

    assign rd_en_v[SIDE_LEFT]    = l_rd_en;
    assign rd_en_v[SIDE_RIGHT]   = r_rd_en;
    assign rd_addr_v[SIDE_LEFT]  = l_rd_addr;
    assign rd_addr_v[SIDE_RIGHT] = r_rd_addr;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        assign we_v[s] = word_vld && (word_side == s[0]);
        sfrx_ring #(.WORD_W(WORD_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) ring_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (we_v[s]),
            .wdata  (word_q),
            .rd_en  (rd_en_v[s]),
            .rd_addr(rd_addr_v[s]),
            .rd_data(rd_data_v[s]),
            .wr_ptr (ptr_v[s]),
            .ovr_evt(ovr_v[s])
        );
    end

    assign l_rd_data = rd_data_v[SIDE_LEFT];
    assign r_rd_data = rd_data_v[SIDE_RIGHT];
    assign l_wr_ptr  = ptr_v[SIDE_LEFT];
    assign r_wr_ptr  = ptr_v[SIDE_RIGHT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_done <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            word_done <= word_vld;
            if (|ovr_v) overrun <= 1'b1;
        end
    end

    // R4: a word goes to at most one buffer
    a_r4_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_v));
    // R9: overrun is sticky
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);
    // R8: a pointer moved in the cycle done is shown
    a_r8_done_moves_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_done) |-> (!$stable(l_wr_ptr) || !$stable(r_wr_ptr)));
endmodule

// File: tb/stereo_flag_rx_tb_top.sv
module stereo_flag_rx_tb_top;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0;
    logic sclk = 1'b0, fsync = 1'b0, sdata = 1'b0, side_flag = 1'b0;
    logic l_rd_addr = 1'b0, l_rd_en = 1'b0, r_rd_addr = 1'b0, r_rd_en = 1'b0;
    logic [W-1:0] l_rd_data, r_rd_data;
    logic l_wr_ptr, r_wr_ptr, word_done, overrun;

    int n_checks = 0, n_fail = 0;
    bit done_flag = 1'b0;
    bit do_read = 1'b1;
    logic [W:0] exp_q [$];
    logic exp_ptr [2] = '{1'b0, 1'b0};

    always #4 clk = ~clk;

    stereo_flag_rx dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sclk(sclk), .fsync(fsync),
        .sdata(sdata), .side_flag(side_flag),
        .l_rd_addr(l_rd_addr), .l_rd_en(l_rd_en), .l_rd_data(l_rd_data), .l_wr_ptr(l_wr_ptr),
        .r_rd_addr(r_rd_addr), .r_rd_en(r_rd_en), .r_rd_data(r_rd_data), .r_wr_ptr(r_wr_ptr),
        .word_done(word_done), .overrun(overrun)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic send_bit(logic fs, logic d, logic f);
        @(negedge clk);
        sclk = 1'b1; fsync = fs; sdata = d; side_flag = f;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // sends bits [W-1 : W-nbits]; flag is inverted except on bit 0 (R4)
    task automatic send_word(logic [W-1:0] data, logic f, int nbits, bit expect_it);
        for (int i = W - 1; i >= W - nbits; i--)
            send_bit(i == W - 1, data[i], (i == 0) ? f : ~f);
        if (expect_it) exp_q.push_back({f, data});
    endtask

    task automatic idle_bits(int n);
        for (int i = 0; i < n; i++) send_bit(1'b0, 1'b1, 1'b1);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && word_done) begin
                if (exp_q.size() == 0) begin
                    check("R6/R8 unexpected word", 1, 0);
                end else begin
                    logic [W:0] e;
                    logic s, old;
                    e = exp_q.pop_front();
                    s = e[W];
                    old = exp_ptr[s];
                    exp_ptr[s] = ~old;
                    if (s) r_rd_addr = old; else l_rd_addr = old;
                    #1;
                    if (s) begin
                        check("R2/R10 right data", r_rd_data, e[W-1:0]);
                        check("R5/R8 right ptr", r_wr_ptr, exp_ptr[1]);
                        check("R4 left ptr untouched", l_wr_ptr, exp_ptr[0]);
                    end else begin
                        check("R2/R10 left data", l_rd_data, e[W-1:0]);
                        check("R5/R8 left ptr", l_wr_ptr, exp_ptr[0]);
                        check("R4 right ptr untouched", r_wr_ptr, exp_ptr[1]);
                    end
                    if (do_read) begin
                        if (s) r_rd_en = 1'b1; else l_rd_en = 1'b1;
                        @(negedge clk);
                        r_rd_en = 1'b0; l_rd_en = 1'b0;
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 left ptr", l_wr_ptr, 0);
        check("R1 right ptr", r_wr_ptr, 0);
        check("R1 word_done", word_done, 0);
        check("R1 overrun", overrun, 0);
        check("R1 left data", l_rd_data, 0);
        check("R1 right data", r_rd_data, 0);

        // R6: nothing received while disabled
        send_word(16'hBEEF, 1'b0, W, 0);
        idle_bits(2);
        check("R6 left ptr while off", l_wr_ptr, 0);
        check("R6 right ptr while off", r_wr_ptr, 0);

        rx_en = 1'b1;
        idle_bits(1);
        // R2 R3 R4 R5: words to both sides, wrap on left
        send_word(16'hA5C3, 1'b0, W, 1);
        idle_bits(1);
        send_word(16'h1234, 1'b1, W, 1);
        send_word(16'hFFFF, 1'b0, W, 1);   // back-to-back (R3)
        send_word(16'h0001, 1'b1, W, 1);
        idle_bits(2);
        send_word(16'h8000, 1'b0, W, 1);
        idle_bits(2);
        check("R5 left wrapped", l_wr_ptr, 1);
        check("R5 right wrapped", r_wr_ptr, 0);

        // R6: disable mid-word drops it
        send_word(16'h5555, 1'b1, 8, 0);
        rx_en = 1'b0;
        for (int i = 7; i >= 0; i--) send_bit(1'b0, 1'b1, 1'b1);
        idle_bits(1);
        // R6: enable mid-word, tail ignored
        send_word(16'h7777, 1'b0, 4, 0);
        rx_en = 1'b1;
        for (int i = 11; i >= 0; i--) send_bit(1'b0, 1'b0, 1'b0);
        idle_bits(2);
        check("R6 left ptr after drop", l_wr_ptr, 1);
        check("R6 right ptr after drop", r_wr_ptr, 0);
        send_word(16'h3C3C, 1'b1, W, 1);
        idle_bits(1);

        // R7: sync mid-word restarts
        send_word(16'hF0F0, 1'b0, 6, 0);
        send_word(16'h0FF0, 1'b0, W, 1);
        idle_bits(2);
        check("R7 left ptr one step", l_wr_ptr, 0);

        // R9: overrun on third unread left write
        check("R9 no overrun yet", overrun, 0);
        do_read = 1'b0;
        send_word(16'h1111, 1'b0, W, 1);
        send_word(16'h2222, 1'b0, W, 1);
        idle_bits(2);
        check("R9 full but no overwrite", overrun, 0);
        send_word(16'h3333, 1'b0, W, 1);
        idle_bits(2);
        check("R9 overrun set", overrun, 1);
        do_read = 1'b1;
        send_word(16'h4444, 1'b1, W, 1);
        idle_bits(2);
        check("R9 overrun sticky", overrun, 1);
        check("R8 all words seen", exp_q.size(), 0);
        finish_run();
    end
endmodule